// File: doc/BRIEF.md
# Floating-Point Environment Image Writer

This block turns a single request to store the floating-point environment into a stream of memory writes. It takes a snapshot of the control, status and tag words, the instruction pointer and code selector, the last opcode, the data pointer and data selector, a base address, and two flags. One flag chooses protected or real/virtual-8086 layout. The other chooses 32-bit or 16-bit operand size. From the snapshot it produces seven words with ascending addresses, one per accepted valid/ready handshake.

In 32-bit layouts each word is a doubleword, 4 bytes apart, and the image is 28 bytes long. In 16-bit layouts each word is 2 bytes apart and sits in the low half of the data bus, and the image is 14 bytes long. In real/virtual-8086 layouts the selector and offset are first folded into a linear address, selector × 16 + offset. That address is then split across fields, and one of those fields also holds the 11-bit opcode.

When the last word has been accepted, the block pulses `done` for one cycle. With that pulse it presents the updated control word, which has all six exception masks set. It also presents the updated status word, which has the busy and error-summary bits cleared. The surrounding core writes both back into its own state.

Top module: `env_image_writer`

## Requirements
- R1: A `start` seen while idle captures all inputs in that cycle. The image is built from that snapshot only. Input changes afterwards, and any `start` while an image is in progress, have no effect on the words written.
- R2: An image is exactly seven writes, at `base + k*4` (32-bit) or `base + k*2` (16-bit) for k = 0..6, in ascending order. `img_len` reads 28 (32-bit) or 14 (16-bit) while the image is written.
- R3: Words 0, 1 and 2 carry the control, status and tag words in bits 15:0. Bits 31:16 are all ones in 32-bit images and all zeros in 16-bit images.
- R4: Protected 32-bit words 3..6: the instruction pointer; the code selector in bits 15:0 with the opcode in bits 26:16 (bits 31:27 zero); the data pointer; the data selector with bits 31:16 all ones.
- R5: Protected 16-bit words 3..6, in bits 15:0 with the upper half zero: instruction pointer bits 15:0, the code selector, data pointer bits 15:0, the data selector.
- R6: Real 32-bit, with LI = code_sel*16 + instr_ptr and LD = data_sel*16 + data_ptr (32-bit wrap). Word 3 is {16'hFFFF, LI[15:0]}. Word 4 has LI[31:16] in bits 27:12 and the opcode in bits 10:0, with every other bit zero. Word 5 is {16'hFFFF, LD[15:0]}. Word 6 has LD[31:16] in bits 27:12 and zeros elsewhere.
- R7: Real 16-bit, with all upper halves zero. Word 3 is LI[15:0]. Word 4 has LI[19:16] in bits 15:12 and the opcode in bits 10:0, with bit 11 zero. Word 5 is LD[15:0]. Word 6 has LD[19:16] in bits 15:12 and zeros elsewhere.
- R8: `wr_valid` stays high with `wr_addr`/`wr_data` unchanged until `wr_ready` is seen. Each handshake advances exactly one word. `wr_ready` while idle has no effect.
- R9: `done` is high for exactly the one cycle after the last handshake, and `wr_valid` is low then. In that cycle, `ctrl_upd` equals the captured control word with bits 5:0 set. `stat_upd` equals the captured status word with bits 15 and 7 cleared.
- R10: After reset, `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to store the environment |
| prot_mode | input | 1 | 1 = protected layout, 0 = real/virtual-8086 layout |
| wide_op | input | 1 | 1 = 32-bit image, 0 = 16-bit image |
| ctrl_word | input | 16 | Control word |
| stat_word | input | 16 | Status word |
| tag_word | input | 16 | Tag word |
| instr_ptr | input | 32 | Last instruction offset |
| code_sel | input | 16 | Last instruction code selector |
| opcode | input | 11 | Last opcode |
| data_ptr | input | 32 | Last operand offset |
| data_sel | input | 16 | Last operand selector |
| base_addr | input | 32 | Byte address of the image |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 32 | Write data |
| img_len | output | 5 | Image length in bytes |
| done | output | 1 | One-cycle pulse after the last write |
| ctrl_upd | output | 16 | Control word to write back |
| stat_upd | output | 16 | Status word to write back |

## Verification
The assertions assume that `wr_ready` is a plain level and that the memory side may stall for any number of cycles. They also assume that `start` may arrive while an image is still in progress. Under those conditions they check that a held word stays fixed and that addresses step by 4 or 2. The stimulus draws `wr_ready` from a fixed-seed random source with several stall rates. After capture it rewrites every data input on each cycle and pulses `start`, so a leak from live inputs into the image would show. Directed cases push the linear-address sums into carry and wrap, use all-ones opcodes and selectors, and place the base address near the top of the address space.

// File: rtl/envw_pkg.sv
package envw_pkg;

  localparam int NWORDS   = 7;
  localparam int IDX_W    = $clog2(NWORDS);
  localparam int ADDR_W   = 32;
  localparam int OPC_W    = 11;
  localparam int EXC_BITS = 6;
  localparam int ST_BUSY  = 15;
  localparam int ST_ESUM  = 7;

  typedef struct packed {
    logic              prot;
    logic              wide;
    logic [15:0]       cw;
    logic [15:0]       sw;
    logic [15:0]       tw;
    logic [31:0]       ip;
    logic [15:0]       cs;
    logic [OPC_W-1:0]  opc;
    logic [31:0]       dp;
    logic [15:0]       ds;
    logic [ADDR_W-1:0] base;
  } env_snap_t;

  // selector * 16 + offset, wrapping at 32 bits
  function automatic logic [31:0] lin_addr(logic [15:0] sel, logic [31:0] off);
    return {12'b0, sel, 4'b0} + off;
  endfunction

  // 16-bit field in a 32-bit or 16-bit slot
  function automatic logic [31:0] pad_field(logic wide, logic [15:0] v);
    return wide ? {16'hFFFF, v} : {16'h0000, v};
  endfunction

  function automatic logic [31:0] img_word(env_snap_t s, logic [IDX_W-1:0] idx);
    logic [31:0] li;
    logic [31:0] ld;
    logic [31:0] w;
    li = lin_addr(s.cs, s.ip);
    ld = lin_addr(s.ds, s.dp);
    w  = '0;
    case (idx)
      3'd0: w = pad_field(s.wide, s.cw);
      3'd1: w = pad_field(s.wide, s.sw);
      3'd2: w = pad_field(s.wide, s.tw);
      3'd3: begin
        if (s.prot) w = s.wide ? s.ip : {16'h0000, s.ip[15:0]};
        else        w = pad_field(s.wide, li[15:0]);
      end
      3'd4: begin
        if (s.prot) w = s.wide ? {5'b0, s.opc, s.cs} : {16'h0000, s.cs};
        else        w = s.wide ? {4'b0, li[31:16], 1'b0, s.opc}
                               : {16'h0000, li[19:16], 1'b0, s.opc};
      end
      3'd5: begin
        if (s.prot) w = s.wide ? s.dp : {16'h0000, s.dp[15:0]};
        else        w = pad_field(s.wide, ld[15:0]);
      end
      3'd6: begin
        if (s.prot) w = pad_field(s.wide, s.ds);
        else        w = s.wide ? {4'b0, ld[31:16], 12'b0}
                               : {16'h0000, ld[19:16], 12'b0};
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] img_addr(env_snap_t s, logic [IDX_W-1:0] idx);
    logic [IDX_W+1:0] off;
    off = s.wide ? {idx, 2'b00} : {1'b0, idx, 1'b0};
    return s.base + ADDR_W'(off);
  endfunction

  function automatic logic [15:0] ctrl_after(logic [15:0] cw);
    return cw | 16'((1 << EXC_BITS) - 1);
  endfunction

  function automatic logic [15:0] stat_after(logic [15:0] sw);
    logic [15:0] r;
    r = sw;
    r[ST_BUSY] = 1'b0;
    r[ST_ESUM] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/envw_capture.sv
module envw_capture
  import envw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  env_snap_t live,
  output env_snap_t snap
);

  always_ff @(posedge clk) begin
    if (!rst_n)       snap <= '0;
    else if (capture) snap <= live;
  end

  // R1
  // snapshot_hold_chk
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> snap == $past(snap));

endmodule

// File: rtl/envw_seq.sv
module envw_seq #(
  parameter int NW = 7,
  localparam int IW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_ready,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          capture,
  output logic          accept,
  output logic          last_hs,
  output logic          done
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

  assign capture = start && !busy;
  assign accept  = busy && wr_ready;
  assign last_hs = accept && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_hs;
      if (capture) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (accept) begin
        if (idx == LAST_IDX) busy <= 1'b0;
        else                 idx  <= idx + 1'b1;
      end
    end
  end

  // R8
  // stall_hold_chk
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr_ready |=> busy && idx == $past(idx));

  // R8
  // step_one_chk
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_hs |=> busy && idx == $past(idx) + 1'b1);

  // R9
  // done_after_last_chk
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_hs |=> done && !busy);

  // R9
  // done_single_chk
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  // busy_keeps_chk
  busy_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_hs |=> busy);

endmodule

// File: rtl/envw_fmt.sv
module envw_fmt
  import envw_pkg::*;
(
  input  env_snap_t         snap,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [4:0]        img_len
);

  localparam logic [4:0] LEN_WIDE   = 5'(NWORDS * 4);
  localparam logic [4:0] LEN_NARROW = 5'(NWORDS * 2);

  always_comb begin
    wr_addr = img_addr(snap, idx);
    wr_data = img_word(snap, idx);
    img_len = snap.wide ? LEN_WIDE : LEN_NARROW;
  end

  // R3
  // narrow_upper_zero_chk
  always_comb begin
    if (!snap.wide) narrow_upper_zero_chk: assert (wr_data[31:16] == 16'h0000);
  end

endmodule

// File: rtl/envw_post.sv
module envw_post
  import envw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        last_hs,
  input  logic [15:0] cw,
  input  logic [15:0] sw,
  output logic [15:0] ctrl_upd,
  output logic [15:0] stat_upd
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_upd <= '0;
      stat_upd <= '0;
    end else if (last_hs) begin
      ctrl_upd <= ctrl_after(cw);
      stat_upd <= stat_after(sw);
    end
  end

endmodule

// File: rtl/env_image_writer.sv
module env_image_writer
  import envw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        prot_mode,
  input  logic        wide_op,
  input  logic [15:0] ctrl_word,
  input  logic [15:0] stat_word,
  input  logic [15:0] tag_word,
  input  logic [31:0] instr_ptr,
  input  logic [15:0] code_sel,
  input  logic [10:0] opcode,
  input  logic [31:0] data_ptr,
  input  logic [15:0] data_sel,
  input  logic [31:0] base_addr,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [4:0]  img_len,
  output logic        done,
  output logic [15:0] ctrl_upd,
  output logic [15:0] stat_upd
);

  env_snap_t        live;
  env_snap_t        snap;
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic             capture;
  logic             accept;
  logic             last_hs;

  always_comb begin
    live.prot = prot_mode;
    live.wide = wide_op;
    live.cw   = ctrl_word;
    live.sw   = stat_word;
    live.tw   = tag_word;
    live.ip   = instr_ptr;
    live.cs   = code_sel;
    live.opc  = opcode;
    live.dp   = data_ptr;
    live.ds   = data_sel;
    live.base = base_addr;
  end

  envw_seq #(.NW(NWORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_ready(wr_ready),
    .busy(busy), .idx(idx), .capture(capture), .accept(accept),
    .last_hs(last_hs), .done(done)
  );

  envw_capture u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .live(live), .snap(snap)
  );

  envw_fmt u_fmt (
    .snap(snap), .idx(idx), .wr_addr(wr_addr), .wr_data(wr_data), .img_len(img_len)
  );

  envw_post u_post (
    .clk(clk), .rst_n(rst_n), .last_hs(last_hs), .cw(snap.cw), .sw(snap.sw),
    .ctrl_upd(ctrl_upd), .stat_upd(stat_upd)
  );

  assign wr_valid = busy;

  // R2
  // addr_step_chk
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_hs |=>
      wr_addr == $past(wr_addr) + ($past(snap.wide) ? 32'd4 : 32'd2));

  // R8
  // data_stable_chk
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_addr) && $stable(wr_data));

  // R9
  // mask_set_chk
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctrl_upd[EXC_BITS-1:0] == '1 && !stat_upd[ST_BUSY] && !stat_upd[ST_ESUM]);

  // R9
  // done_idle_chk
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  // R10
  // reset_quiet_chk
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !wr_valid && !done);

endmodule

// File: tb/tb_env_image_writer.sv
`timescale 1ns/1ps
module tb_env_image_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prot_mode = 1'b0;
  logic        wide_op = 1'b0;
  logic [15:0] ctrl_word = '0, stat_word = '0, tag_word = '0, code_sel = '0, data_sel = '0;
  logic [31:0] instr_ptr = '0, data_ptr = '0, base_addr = '0;
  logic [10:0] opcode = '0;
  logic        wr_ready = 1'b0;
  logic        wr_valid, done;
  logic [31:0] wr_addr, wr_data;
  logic [4:0]  img_len;
  logic [15:0] ctrl_upd, stat_upd;

  env_image_writer dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  bit          f_prot, f_wide;
  logic [15:0] f_cw, f_sw, f_tw, f_cs, f_ds;
  logic [31:0] f_ip, f_dp, f_base;
  logic [10:0] f_opc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int k);
    logic [31:0] li, ld, v;
    li = ({16'b0, f_cs} * 32'd16) + f_ip;
    ld = ({16'b0, f_ds} * 32'd16) + f_dp;
    if (k < 3) begin
      v = (k == 0) ? {16'b0, f_cw} : (k == 1) ? {16'b0, f_sw} : {16'b0, f_tw};
      return f_wide ? (32'hFFFF0000 | v) : v;
    end
    if (f_prot && f_wide) begin
      case (k)
        3: return f_ip;
        4: return ({21'b0, f_opc} << 16) | {16'b0, f_cs};
        5: return f_dp;
        default: return 32'hFFFF0000 | {16'b0, f_ds};
      endcase
    end else if (f_prot) begin
      case (k)
        3: return f_ip & 32'hFFFF;
        4: return {16'b0, f_cs};
        5: return f_dp & 32'hFFFF;
        default: return {16'b0, f_ds};
      endcase
    end else if (f_wide) begin
      case (k)
        3: return 32'hFFFF0000 | (li & 32'hFFFF);
        4: return ((li & 32'hFFFF0000) >> 4) | {21'b0, f_opc};
        5: return 32'hFFFF0000 | (ld & 32'hFFFF);
        default: return (ld & 32'hFFFF0000) >> 4;
      endcase
    end else begin
      case (k)
        3: return li & 32'hFFFF;
        4: return ((li & 32'h000F0000) >> 4) | {21'b0, f_opc};
        5: return ld & 32'hFFFF;
        default: return (ld & 32'h000F0000) >> 4;
      endcase
    end
  endfunction

  function automatic string req_of(int k);
    if (k < 3) return "R3";
    if (f_prot) return f_wide ? "R4" : "R5";
    return f_wide ? "R6" : "R7";
  endfunction

  task automatic scramble_inputs();
    ctrl_word = 16'($urandom); stat_word = 16'($urandom); tag_word = 16'($urandom);
    instr_ptr = $urandom; code_sel = 16'($urandom); opcode = 11'($urandom);
    data_ptr = $urandom; data_sel = 16'($urandom); base_addr = $urandom;
    prot_mode = 1'($urandom); wide_op = 1'($urandom);
  endtask

  // Runs one image; fields already set in f_*; stall_pct = chance of ready low
  task automatic run_image(input int stall_pct);
    int k;
    logic [31:0] step;
    @(negedge clk);
    prot_mode = f_prot; wide_op = f_wide; ctrl_word = f_cw; stat_word = f_sw;
    tag_word = f_tw; instr_ptr = f_ip; code_sel = f_cs; opcode = f_opc;
    data_ptr = f_dp; data_sel = f_ds; base_addr = f_base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step = f_wide ? 32'd4 : 32'd2;
    chk("R2 img_len", {27'b0, img_len}, f_wide ? 32'd28 : 32'd14);
    k = 0;
    while (k < 7) begin
      wr_ready = (int'($urandom % 100) >= stall_pct);
      chk("R8 valid", {31'b0, wr_valid}, 32'd1);
      chk("R2 addr", wr_addr, f_base + step * k);
      chk(req_of(k), wr_data, exp_word(k));
      if (wr_ready) k++;
      // R1: live inputs and extra starts must not disturb the image
      scramble_inputs();
      start = ($urandom % 3 == 0);
      @(negedge clk);
    end
    wr_ready = 1'b0;
    start = 1'b0;
    chk("R9 done", {31'b0, done}, 32'd1);
    chk("R9 valid low", {31'b0, wr_valid}, 32'd0);
    chk("R9 ctrl_upd", {16'b0, ctrl_upd}, {16'b0, f_cw | 16'h003F});
    chk("R9 stat_upd", {16'b0, stat_upd}, {16'b0, f_sw & 16'h7F7F});
    @(negedge clk);
    chk("R9 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic set_fields(bit p, bit w);
    f_prot = p; f_wide = w;
    f_cw = 16'($urandom); f_sw = 16'($urandom); f_tw = 16'($urandom);
    f_ip = $urandom; f_cs = 16'($urandom); f_opc = 11'($urandom);
    f_dp = $urandom; f_ds = 16'($urandom); f_base = $urandom;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", {31'b0, wr_valid}, 32'd0);
    chk("R10 done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 ready while idle does nothing
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle valid", {31'b0, wr_valid}, 32'd0);
    chk("R8 idle done", {31'b0, done}, 32'd0);
    wr_ready = 1'b0;

    // directed corners: every layout with carries, all-ones fields, base wrap
    for (int m = 0; m < 4; m++) begin
      set_fields(m[1], m[0]);
      f_cs = 16'hFFFF; f_ip = 32'hFFFF_FFF8; f_ds = 16'hF123; f_dp = 32'h0001_FFFF;
      f_opc = 11'h7FF; f_base = 32'hFFFF_FFF0; f_sw = 16'hFFFF; f_cw = 16'h0000;
      run_image(0);
    end
    for (int m = 0; m < 4; m++) begin
      set_fields(m[1], m[0]);
      f_cs = 16'h1234; f_ip = 32'h0000_5678; f_sw = 16'h0080; f_cw = 16'hFFC0;
      run_image(60);
    end
    // random mix
    for (int n = 0; n < 120; n++) begin
      set_fields(1'($urandom), 1'($urandom));
      run_image(int'($urandom % 80));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule